// File: doc/BRIEF.md
# I2C Ten-Bit Slave Address Matcher

This block decides, byte by byte, whether an I2C slave that answers to a 10-bit address should acknowledge an address byte. A byte-level front end supplies each received byte with a one-cycle strobe. It also supplies one-cycle pulses for a start, a repeated start and a stop. The block compares the bytes against a programmed address, bit by bit under a care mask. It returns an acknowledge decision for every strobed byte. It also keeps a level flag that stays high while the slave is addressed.

Matching runs in two steps. The first byte is a header. It carries a fixed five-bit prefix, the two top address bits and a direction bit. If the header matches, the next byte is compared with the low eight address bits. A full match sets the addressed flag. While the flag is high, a repeated start followed by a read-direction header is acknowledged, which lets the master turn the transfer around. The address and mask registers can be changed only while the interface is disabled. While the flag is high, the address readback shows the address actually received.

Top module: `i2c_tenbit_addr_match`

## Requirements
- R1: After reset the mask reads 16'h03FF, the address reads 0, the addressed flag is 0 and no acknowledge pulse is present.
- R2: A register write with reg_sel=0 loads the address from reg_wdata[9:0], and a write with reg_sel=1 loads the mask from the same bits. The write only takes effect while ctl_enable is 0, and a write made while it is 1 changes nothing. Bits 15:10 of both readbacks are always 0.
- R3: A write-direction header is byte[7:3]=5'b11110, byte[2:1]=address bits 9:8 and byte[0]=0. It is acknowledged only after a start, only with ctl_tenbit=1, and only if byte[2:1] matches under the mask. Any other first byte, including a read-direction header (byte[0]=1), is not acknowledged.
- R4: ack_valid is high for exactly the one cycle after each byte_valid strobe, and ack can be 1 only in that cycle. Bytes that arrive once the address phase is over (data bytes) get ack=0.
- R5: The byte after an acknowledged write header is compared with address bits 7:0 under the mask. On a match it is acknowledged and slave_hit rises in the same cycle as that ack.
- R6: A mask bit of 0 makes the matching address bit compare equal whatever value was received. A mask bit of 1 requires equality.
- R7: After a repeated start, a read-direction header whose bits 2:1 match is acknowledged only if slave_hit is 1. It is not acknowledged when no full match came before.
- R8: While slave_hit is 1, addr_rd shows the received 10-bit address. Otherwise it shows the programmed address.
- R9: A stop or a plain start clears slave_hit in the following cycle.
- R10: A header or low byte that does not match is not acknowledged. Later bytes are also not acknowledged until the next start.
- R11: While ctl_enable is 0, slave_hit is cleared and no byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_enable | input | 1 | Interface enable; register writes need it low |
| ctl_tenbit | input | 1 | Allows ten-bit address matching |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 the mask register |
| reg_wdata | input | 16 | Register write data; bits 9:0 are used |
| start_pulse | input | 1 | Start condition seen (not repeated) |
| rstart_pulse | input | 1 | Repeated start seen |
| stop_pulse | input | 1 | Stop condition seen |
| byte_valid | input | 1 | Received-byte strobe |
| byte_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision valid, one cycle after byte_valid |
| ack | output | 1 | 1 = acknowledge the byte, 0 = no acknowledge |
| slave_hit | output | 1 | Addressed-as-slave flag (level) |
| addr_rd | output | 16 | Address readback |
| mask_rd | output | 16 | Mask readback |

## Verification
The assertions check on every cycle the timing relations that follow from the strobes:
- the one-cycle acknowledge window after each byte;
- slave_hit rising only together with an acknowledge;
- the clearing of slave_hit by a stop, a plain start or a disable;
- the frozen mask while the interface is enabled;
- the zero upper readback bits.

Whether a given byte should be acknowledged depends on the register contents, the mask and the history since the last start. The bench's reference model and its directed scenarios show this. They cover masked and unmasked bits, wrong prefixes, read headers with and without an earlier full match, and the readback of the received address.

// File: rtl/i2c_tba_pkg.sv
package i2c_tba_pkg;

    // Address-phase progress since the last start condition.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // not addressed, waiting for a start
        ST_HDR  = 3'd1,   // expecting a header byte
        ST_LOW  = 3'd2,   // header accepted, expecting low address byte
        ST_RHDR = 3'd3,   // repeated start while addressed
        ST_DATA = 3'd4    // address phase complete
    } tba_state_e;

endpackage

// File: rtl/i2c_tba_regs.sv
module i2c_tba_regs #(
    parameter int ADDR_W = 10,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic              hit,
    input  logic [ADDR_W-1:0] rx_addr,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [ADDR_W-1:0] cfg_mask,
    output logic [REG_W-1:0]  addr_rd,
    output logic [REG_W-1:0]  mask_rd
);

    localparam int PAD_W = REG_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
    } regs_s;

    regs_s r_d, r_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[REG_W-1:ADDR_W];

    always_comb begin
        r_d = r_q;
        if (wr && !enable) begin
            if (sel) begin
                r_d.mask = wdata[ADDR_W-1:0];
            end else begin
                r_d.addr = wdata[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.addr <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_addr = r_q.addr;
    assign cfg_mask = r_q.mask;
    assign addr_rd  = {{PAD_W{1'b0}}, (hit ? rx_addr : r_q.addr)};
    assign mask_rd  = {{PAD_W{1'b0}}, r_q.mask};

endmodule

// File: rtl/i2c_tba_cmp.sv
module i2c_tba_cmp #(
    parameter int ADDR_W = 10
) (
    input  logic [7:0]        byte_data,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_mask,
    output logic              hdr_wr_ok,
    output logic              hdr_rd_ok,
    output logic              low_ok
);

    localparam int HI_W = ADDR_W - 8;
    localparam int PW   = 7 - HI_W;
    localparam logic [PW-1:0] PREFIX = {{(PW-1){1'b1}}, 1'b0};

    // Candidate address formed from one byte: the high part is taken from
    // the header's address field, the low part from the whole byte.
    logic [ADDR_W-1:0] cand;
    logic [ADDR_W-1:0] bit_hit;

    assign cand = {byte_data[HI_W:1], byte_data};

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_hit[i] = ~cfg_mask[i] | (cand[i] == cfg_addr[i]);
    end

    logic prefix_ok;
    logic hi_ok;

    assign prefix_ok = (byte_data[7:HI_W+1] == PREFIX);
    assign hi_ok     = &bit_hit[ADDR_W-1:8];
    assign hdr_wr_ok = prefix_ok && hi_ok && !byte_data[0];
    assign hdr_rd_ok = prefix_ok && hi_ok &&  byte_data[0];
    assign low_ok    = &bit_hit[7:0];

endmodule

// File: rtl/i2c_tba_fsm.sv
module i2c_tba_fsm
    import i2c_tba_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tenbit_en,
    input  logic              start,
    input  logic              rstart,
    input  logic              stop,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              hdr_wr_ok,
    input  logic              hdr_rd_ok,
    input  logic              low_ok,
    output logic              ack_valid,
    output logic              ack,
    output logic              hit,
    output logic [ADDR_W-1:0] rx_addr
);

    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        tba_state_e        st;
        logic              hit;
        logic [ADDR_W-1:0] rx;
        logic              av;
        logic              ack;
    } fsm_s;

    fsm_s s_d, s_q;

    logic wr_hdr, rd_hdr, low_hit;
    assign wr_hdr  = tenbit_en && hdr_wr_ok;
    assign rd_hdr  = tenbit_en && hdr_rd_ok;
    assign low_hit = tenbit_en && low_ok;

    always_comb begin
        s_d     = s_q;
        s_d.av  = byte_valid;
        s_d.ack = 1'b0;
        if (!enable) begin
            s_d.st  = ST_IDLE;
            s_d.hit = 1'b0;
        end else if (stop) begin
            s_d.st  = ST_IDLE;
            s_d.hit = 1'b0;
        end else if (start) begin
            s_d.st  = ST_HDR;
            s_d.hit = 1'b0;
        end else if (rstart) begin
            s_d.st = s_q.hit ? ST_RHDR : ST_HDR;
        end else if (byte_valid) begin
            unique case (s_q.st)
                ST_HDR: begin
                    if (wr_hdr) begin
                        s_d.ack = 1'b1;
                        s_d.st  = ST_LOW;
                        s_d.rx[ADDR_W-1:8] = byte_data[HI_W:1];
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
                ST_LOW: begin
                    if (low_hit) begin
                        s_d.ack = 1'b1;
                        s_d.hit = 1'b1;
                        s_d.st  = ST_DATA;
                        s_d.rx[7:0] = byte_data;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
                ST_RHDR: begin
                    if (rd_hdr) begin
                        s_d.ack = 1'b1;
                        s_d.st  = ST_DATA;
                    end else if (wr_hdr) begin
                        s_d.ack = 1'b1;
                        s_d.hit = 1'b0;
                        s_d.st  = ST_LOW;
                        s_d.rx[ADDR_W-1:8] = byte_data[HI_W:1];
                    end else begin
                        s_d.hit = 1'b0;
                        s_d.st  = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.hit <= 1'b0;
            s_q.rx  <= '0;
            s_q.av  <= 1'b0;
            s_q.ack <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_valid = s_q.av;
    assign ack       = s_q.ack;
    assign hit       = s_q.hit;
    assign rx_addr   = s_q.rx;

endmodule

// File: rtl/i2c_tenbit_addr_match.sv
module i2c_tenbit_addr_match #(
    parameter int ADDR_W = 10,
    parameter int REG_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_enable,
    input  logic             ctl_tenbit,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             start_pulse,
    input  logic             rstart_pulse,
    input  logic             stop_pulse,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             ack_valid,
    output logic             ack,
    output logic             slave_hit,
    output logic [REG_W-1:0] addr_rd,
    output logic [REG_W-1:0] mask_rd
);

    logic [ADDR_W-1:0] cfg_addr, cfg_mask, rx_addr;
    logic              hdr_wr_ok, hdr_rd_ok, low_ok;

    i2c_tba_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctl_enable),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .hit      (slave_hit),
        .rx_addr  (rx_addr),
        .cfg_addr (cfg_addr),
        .cfg_mask (cfg_mask),
        .addr_rd  (addr_rd),
        .mask_rd  (mask_rd)
    );

    i2c_tba_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .byte_data (byte_data),
        .cfg_addr  (cfg_addr),
        .cfg_mask  (cfg_mask),
        .hdr_wr_ok (hdr_wr_ok),
        .hdr_rd_ok (hdr_rd_ok),
        .low_ok    (low_ok)
    );

    i2c_tba_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctl_enable),
        .tenbit_en  (ctl_tenbit),
        .start      (start_pulse),
        .rstart     (rstart_pulse),
        .stop       (stop_pulse),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .hdr_wr_ok  (hdr_wr_ok),
        .hdr_rd_ok  (hdr_rd_ok),
        .low_ok     (low_ok),
        .ack_valid  (ack_valid),
        .ack        (ack),
        .hit        (slave_hit),
        .rx_addr    (rx_addr)
    );

endmodule

// File: rtl/i2c_tba_chk.sv
module i2c_tba_chk #(
    parameter int ADDR_W = 10,
    parameter int REG_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_enable,
    input logic             start_pulse,
    input logic             stop_pulse,
    input logic             byte_valid,
    input logic             ack_valid,
    input logic             ack,
    input logic             slave_hit,
    input logic [REG_W-1:0] addr_rd,
    input logic [REG_W-1:0] mask_rd
);

    assert_ack_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> ack_valid);

    assert_no_stray_ack_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> !ack_valid);

    assert_ack_inside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ack_valid);

    assert_hit_rises_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slave_hit) |-> ack);

    assert_stop_clears_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !slave_hit);

    assert_start_clears_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !slave_hit);

    assert_disable_clears_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !slave_hit);

    assert_mask_frozen_when_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_enable |=> $stable(mask_rd));

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_rd[REG_W-1:ADDR_W] == '0) && (mask_rd[REG_W-1:ADDR_W] == '0));

endmodule

bind i2c_tenbit_addr_match i2c_tba_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_enable  (ctl_enable),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .byte_valid  (byte_valid),
    .ack_valid   (ack_valid),
    .ack         (ack),
    .slave_hit   (slave_hit),
    .addr_rd     (addr_rd),
    .mask_rd     (mask_rd)
);

// File: tb/i2c_tenbit_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_tenbit_addr_match_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_enable = 1'b0;
    logic        ctl_tenbit = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        start_pulse = 1'b0;
    logic        rstart_pulse = 1'b0;
    logic        stop_pulse = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        ack_valid, ack, slave_hit;
    logic [15:0] addr_rd, mask_rd;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    i2c_tenbit_addr_match u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_tenbit(ctl_tenbit),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .start_pulse(start_pulse), .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .ack_valid(ack_valid), .ack(ack), .slave_hit(slave_hit),
        .addr_rd(addr_rd), .mask_rd(mask_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 want header, 2 want low byte,
    // 3 repeated start while addressed, 4 address phase done.
    int      m_phase = 0;
    bit      m_hit = 0, m_av = 0, m_ack = 0;
    int      m_addr = 0, m_mask = 'h3FF, m_rx = 0;

    function automatic bit field_eq(int rx, int ref_a, int msk);
        return ((rx ^ ref_a) & msk) == 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_hit = 0; m_av = 0; m_ack = 0;
            m_addr = 0; m_mask = 'h3FF; m_rx = 0;
        end else begin
            bit is_pref, hi_eq, lo_eq;
            is_pref = (byte_data[7:3] == 5'b11110);
            hi_eq   = field_eq(int'(byte_data[2:1]), m_addr >> 8, m_mask >> 8);
            lo_eq   = field_eq(int'(byte_data), m_addr & 'hFF, m_mask & 'hFF);
            m_av  = byte_valid;
            m_ack = 0;
            if (!ctl_enable) begin
                m_phase = 0; m_hit = 0;
            end else if (stop_pulse) begin
                m_phase = 0; m_hit = 0;
            end else if (start_pulse) begin
                m_phase = 1; m_hit = 0;
            end else if (rstart_pulse) begin
                m_phase = m_hit ? 3 : 1;
            end else if (byte_valid) begin
                bit wr_h, rd_h;
                wr_h = ctl_tenbit && is_pref && hi_eq && !byte_data[0];
                rd_h = ctl_tenbit && is_pref && hi_eq &&  byte_data[0];
                if (m_phase == 1) begin
                    if (wr_h) begin
                        m_ack = 1; m_phase = 2;
                        m_rx = (m_rx & 'hFF) | (int'(byte_data[2:1]) << 8);
                    end else m_phase = 0;
                end else if (m_phase == 2) begin
                    if (ctl_tenbit && lo_eq) begin
                        m_ack = 1; m_hit = 1; m_phase = 4;
                        m_rx = (m_rx & 'h300) | int'(byte_data);
                    end else m_phase = 0;
                end else if (m_phase == 3) begin
                    if (rd_h) begin
                        m_ack = 1; m_phase = 4;
                    end else if (wr_h) begin
                        m_ack = 1; m_hit = 0; m_phase = 2;
                        m_rx = (m_rx & 'hFF) | (int'(byte_data[2:1]) << 8);
                    end else begin
                        m_hit = 0; m_phase = 0;
                    end
                end
            end
            if (reg_wr && !ctl_enable) begin
                if (reg_sel) m_mask = int'(reg_wdata[9:0]);
                else         m_addr = int'(reg_wdata[9:0]);
            end
        end
    end

    // Compare the model with the outputs every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 ack_valid vs model", int'(ack_valid), int'(m_av));
            check("R5 ack vs model", int'(ack), int'(m_ack));
            check("R5 slave_hit vs model", int'(slave_hit), int'(m_hit));
            check("R8 addr_rd vs model", int'(addr_rd), m_hit ? m_rx : m_addr);
            check("R2 mask_rd vs model", int'(mask_rd), m_mask);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr_reg(input bit sel, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask
    task automatic do_start();
        @(negedge clk); start_pulse = 1; @(negedge clk); start_pulse = 0;
    endtask
    task automatic do_rstart();
        @(negedge clk); rstart_pulse = 1; @(negedge clk); rstart_pulse = 0;
    endtask
    task automatic do_stop();
        @(negedge clk); stop_pulse = 1; @(negedge clk); stop_pulse = 0;
    endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_valid = 1; byte_data = b;
        @(negedge clk); byte_valid = 0;
    endtask
    task automatic set_en(input bit v);
        @(negedge clk); ctl_enable = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset mask", int'(mask_rd), 'h03FF);
        check("R1 reset addr", int'(addr_rd), 0);
        check("R1 reset hit", int'(slave_hit), 0);
        check("R1 reset ack_valid", int'(ack_valid), 0);

        wr_reg(0, 16'hFEA5);
        check("R2 upper bits dropped", int'(addr_rd), 'h02A5);
        @(negedge clk); ctl_enable = 1; ctl_tenbit = 1;
        wr_reg(0, 16'h0111);
        check("R2 addr write ignored when enabled", int'(addr_rd), 'h02A5);
        wr_reg(1, 16'h0000);
        check("R2 mask write ignored when enabled", int'(mask_rd), 'h03FF);

        do_start();
        send(8'hF4);
        check("R3 write header ack", int'(ack), 1);
        check("R4 ack_valid after header", int'(ack_valid), 1);
        send(8'hA5);
        check("R5 low byte ack", int'(ack), 1);
        check("R5 hit set", int'(slave_hit), 1);
        check("R8 received address", int'(addr_rd), 'h02A5);
        do_rstart();
        send(8'hF5);
        check("R7 read header after match", int'(ack), 1);
        check("R7 hit kept", int'(slave_hit), 1);
        send(8'h12);
        check("R4 data byte not acked", int'(ack), 0);
        check("R4 data byte window", int'(ack_valid), 1);
        do_stop();
        check("R9 stop clears hit", int'(slave_hit), 0);

        do_start();
        send(8'hF2);
        check("R10 wrong header nack", int'(ack), 0);
        send(8'hA5);
        check("R10 stays idle after miss", int'(ack), 0);
        check("R10 no hit", int'(slave_hit), 0);
        do_start();
        send(8'hF4);
        send(8'hA4);
        check("R10 wrong low byte nack", int'(ack), 0);
        do_rstart();
        send(8'hF5);
        check("R7 read header without match", int'(ack), 0);
        do_start();
        send(8'hF5);
        check("R3 read header first nack", int'(ack), 0);
        do_start();
        send(8'h74);
        check("R3 bad prefix nack", int'(ack), 0);

        set_en(0);
        wr_reg(1, 16'h03F0);
        set_en(1);
        do_start();
        send(8'hF4);
        send(8'hAB);
        check("R6 masked low nibble ack", int'(ack), 1);
        check("R8 readback shows received", int'(addr_rd), 'h02AB);
        do_stop();
        check("R8 readback returns to programmed", int'(addr_rd), 'h02A5);

        set_en(0);
        wr_reg(1, 16'h00FF);
        set_en(1);
        do_start();
        send(8'hF6);
        check("R6 masked high bits ack", int'(ack), 1);
        send(8'hA5);
        check("R8 received high bits", int'(addr_rd), 'h03A5);
        do_start();
        check("R9 plain start clears hit", int'(slave_hit), 0);

        send(8'hF6);
        send(8'hA5);
        check("R5 hit before disable", int'(slave_hit), 1);
        set_en(0);
        @(negedge clk);
        check("R11 disable clears hit", int'(slave_hit), 0);
        send(8'hF4);
        check("R11 no ack while disabled", int'(ack), 0);
        set_en(1);

        @(negedge clk); ctl_tenbit = 0;
        do_start();
        send(8'hF4);
        check("R3 ten-bit off nack", int'(ack), 0);
        @(negedge clk); ctl_tenbit = 1;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule